// File: doc/BRIEF.md
# Framed Serial Link Transceiver

This block carries a 35-bit parallel word over one serial wire. The transmit half takes a word on a one-cycle write strobe and sends it as a 44-bit frame, one bit per clock. It holds a busy flag until the last bit has left. The receive half watches the wire and recognises the leading bit of a frame. It collects the remaining bits, checks the start code, the two parity bits and the end code, and then presents the word with a ready flag. The word and the ready flag stay put until the consumer pulses a read strobe.

The serial line is a plain digital wire that rests low. Each half has its own sleep input. Sleep keeps that half in its idle state, so no new frame can start. A frame that is already in flight always finishes.

Transmit states: `TX_IDLE`, `TX_START`, `TX_BODY`, `TX_PAR`, `TX_TAIL`. The transitions are launch (`TX_IDLE`→`TX_START` on an accepted write), start-done, body-done and parity-done. Each of the last three fires on the final bit of its phase. The last transition is tail-done (`TX_TAIL`→`TX_IDLE` after frame bit 43). The receive states `RX_IDLE`, `RX_START`, `RX_BODY`, `RX_PAR` and `RX_TAIL` follow the same transitions. The one difference is the first one: the receive side's detect transition (`RX_IDLE`→`RX_START`) fires when it samples a 1 on the line while awake. The receive side's tail-done transition is the cycle in which the frame completes.

Top module: `sflink_xcvr`

## Requirements
- R1: Frame bit order on the wire is as follows. Bits 0..2 are 1,0,1. Bits 3..37 are the payload, LSB first. Bit 38 is parity P0 and bit 39 is parity P1. Bits 40..43 are 0. Frame bit 0 appears on `ser_out` in the cycle after the clock edge that accepts the write, and `ser_out` is 0 whenever no frame is being sent.
- R2: `tx_busy` rises at the accepting edge and stays high for exactly 44 cycles.
- R3: A write while `tx_busy` is high, or while `tx_sleep` is high, is ignored. The frame in flight is unchanged, and with sleep no frame starts.
- R4: P0 is the XOR of payload bits 0,2,4,…,34. P1 is the XOR of payload bits 1,3,…,33. This makes even parity over each half including its parity bit.
- R5: At the edge that samples frame bit 43, `rx_data` takes the payload and `rx_ready` goes to 1. Both then hold until an `rx_rd` pulse, which clears `rx_ready`. `rx_data` keeps its value after the read.
- R6: If a frame completes while `rx_ready` is 1 and `rx_rd` is 0, `rx_ovw_err` is 1 and `rx_data` holds the newer payload.
- R7: `rx_par_err` is 1 when either received parity bit disagrees with R4.
- R8: `rx_frm_err` is 1 when the start bits are not 1,0,1 or the end bits are not all 0.
- R9: While `rx_sleep` is high in `RX_IDLE`, no frame is detected and the receive outputs do not change. After wake, frames are received again.
- R10: If `rx_rd` falls in the completion cycle, `rx_ready` stays 1, `rx_data` is the new payload and `rx_ovw_err` is 0.
- R11: The three error flags are refreshed at every frame completion and otherwise hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one frame bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sleep | input | 1 | Holds the transmitter idle |
| tx_wr | input | 1 | Write strobe; latches `tx_data` |
| tx_data | input | 35 | Word to send |
| tx_busy | output | 1 | High while a frame is being sent |
| ser_out | output | 1 | Serial line driven by the transmitter |
| rx_sleep | input | 1 | Holds the receiver idle |
| ser_in | input | 1 | Serial line sampled by the receiver |
| rx_rd | input | 1 | Read strobe; clears `rx_ready` |
| rx_data | output | 35 | Last received word |
| rx_ready | output | 1 | An unread word is present |
| rx_par_err | output | 1 | Parity mismatch in last frame |
| rx_frm_err | output | 1 | Start or end code wrong in last frame |
| rx_ovw_err | output | 1 | Last frame replaced an unread word |

## Verification
Two receive functions can land in the same cycle: completing a frame and consuming the previous word. The bench provokes this by injecting a frame with `rx_rd` raised while bit 43 is on the wire, with an older unread word already present. Since the read drained the old word, the bench judges correct behaviour to be the new payload with `rx_ready` still high and no overwrite flag. Without the read the same sequence must raise the overwrite flag. On the transmit side, a write is placed mid-frame, and the serial bits and busy length are compared against the original word.

// File: rtl/sflink_pkg.sv
package sflink_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_BODY,
        TX_PAR,
        TX_TAIL
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BODY,
        RX_PAR,
        RX_TAIL
    } rx_state_e;

endpackage

// File: rtl/sflink_parity.sv
// Split parity: even-indexed bits and odd-indexed bits, each XOR-reduced.
module sflink_parity #(
    parameter int unsigned W = 35
) (
    input  logic [W-1:0] word,
    output logic         p_even_idx,
    output logic         p_odd_idx
);
    logic [W-1:0] even_sel;
    logic [W-1:0] odd_sel;

    for (genvar i = 0; i < W; i++) begin : g_split
        if ((i % 2) == 0) begin : g_ev
            assign even_sel[i] = word[i];
            assign odd_sel[i]  = 1'b0;
        end else begin : g_od
            assign even_sel[i] = 1'b0;
            assign odd_sel[i]  = word[i];
        end
    end

    assign p_even_idx = ^even_sel;
    assign p_odd_idx  = ^odd_sel;
endmodule

// File: rtl/sflink_tx.sv
// Frame serializer. SW must be at least 2.
module sflink_tx
    import sflink_pkg::*;
#(
    parameter int unsigned PAY_W     = 35,
    parameter int unsigned SW        = 3,
    parameter int unsigned EW        = 4,
    parameter logic [SW-1:0] START_PAT = 3'b101,
    parameter logic [EW-1:0] END_PAT   = 4'b0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_sleep,
    input  logic             tx_wr,
    input  logic [PAY_W-1:0] tx_data,
    output logic             tx_busy,
    output logic             ser_out
);
    localparam int unsigned FRM_W = SW + PAY_W + 2 + EW;
    localparam int unsigned CW    = $clog2(FRM_W);
    localparam logic [CW-1:0] LAST_START = CW'(SW - 1);
    localparam logic [CW-1:0] LAST_BODY  = CW'(SW + PAY_W - 1);
    localparam logic [CW-1:0] LAST_PAR   = CW'(SW + PAY_W + 1);
    localparam logic [CW-1:0] LAST_BIT   = CW'(FRM_W - 1);

    tx_state_e        state, nxt;
    logic [FRM_W-1:0] sh;
    logic [FRM_W-1:0] frame;
    logic [CW-1:0]    pos;
    logic             pe, po;
    logic             launch;

    sflink_parity #(.W(PAY_W)) u_par (
        .word       (tx_data),
        .p_even_idx (pe),
        .p_odd_idx  (po)
    );

    always_comb begin
        frame = '0;
        for (int i = 0; i < int'(SW); i++) frame[i] = START_PAT[SW-1-i];
        frame[SW +: PAY_W]  = tx_data;
        frame[SW + PAY_W]   = pe;
        frame[SW + PAY_W + 1] = po;
        for (int i = 0; i < int'(EW); i++) frame[FRM_W-EW+i] = END_PAT[EW-1-i];
    end

    assign launch = (state == TX_IDLE) && tx_wr && !tx_sleep;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (launch)            nxt = TX_START;
            TX_START: if (pos == LAST_START) nxt = TX_BODY;
            TX_BODY:  if (pos == LAST_BODY)  nxt = TX_PAR;
            TX_PAR:   if (pos == LAST_PAR)   nxt = TX_TAIL;
            TX_TAIL:  if (pos == LAST_BIT)   nxt = TX_IDLE;
            default:                         nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            pos <= '0;
        end else if (launch) begin
            sh  <= frame;
            pos <= '0;
        end else if (state != TX_IDLE) begin
            sh  <= {1'b0, sh[FRM_W-1:1]};
            pos <= (nxt == TX_IDLE) ? '0 : pos + 1'b1;
        end
    end

    always_comb begin
        tx_busy = (state != TX_IDLE);
        ser_out = sh[0];
    end

    // Checker state: length of the current busy run.
    logic [CW:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= '0;
        else if (tx_busy) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && $past(tx_busy)) |-> (run_len == (CW+1)'(FRM_W)));

    p_line_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !ser_out);

    p_sleep_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && tx_sleep) |=> !tx_busy);

    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_wr && !tx_sleep));
endmodule

// File: rtl/sflink_rx.sv
// Frame deserializer and checker. SW must be at least 2.
module sflink_rx
    import sflink_pkg::*;
#(
    parameter int unsigned PAY_W     = 35,
    parameter int unsigned SW        = 3,
    parameter int unsigned EW        = 4,
    parameter logic [SW-1:0] START_PAT = 3'b101,
    parameter logic [EW-1:0] END_PAT   = 4'b0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sleep,
    input  logic             ser_in,
    input  logic             rx_rd,
    output logic [PAY_W-1:0] rx_data,
    output logic             rx_ready,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_ovw_err
);
    localparam int unsigned FRM_W = SW + PAY_W + 2 + EW;
    localparam int unsigned CW    = $clog2(FRM_W);
    localparam logic [CW-1:0] LAST_START = CW'(SW - 1);
    localparam logic [CW-1:0] LAST_BODY  = CW'(SW + PAY_W - 1);
    localparam logic [CW-1:0] LAST_PAR   = CW'(SW + PAY_W + 1);
    localparam logic [CW-1:0] LAST_BIT   = CW'(FRM_W - 1);

    rx_state_e        state, nxt;
    logic [FRM_W-1:0] sh;
    logic [FRM_W-1:0] full;
    logic [CW-1:0]    pos;
    logic             detect, done;
    logic [SW-1:0]    st_exp;
    logic [EW-1:0]    end_exp;
    logic [PAY_W-1:0] pay;
    logic             pe, po, bad_par, bad_frm;

    logic [PAY_W-1:0] data_q;
    logic             rdy_q, par_q, frm_q, ovw_q;

    assign full   = {ser_in, sh[FRM_W-1:1]};
    assign detect = (state == RX_IDLE) && ser_in && !rx_sleep;
    assign done   = (state == RX_TAIL) && (pos == LAST_BIT);
    assign pay    = full[SW +: PAY_W];

    sflink_parity #(.W(PAY_W)) u_par (
        .word       (pay),
        .p_even_idx (pe),
        .p_odd_idx  (po)
    );

    always_comb begin
        for (int i = 0; i < int'(SW); i++) st_exp[i]  = START_PAT[SW-1-i];
        for (int i = 0; i < int'(EW); i++) end_exp[i] = END_PAT[EW-1-i];
        bad_par = (full[SW+PAY_W] != pe) || (full[SW+PAY_W+1] != po);
        bad_frm = (full[SW-1:0] != st_exp) || (full[FRM_W-1 -: EW] != end_exp);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (detect)            nxt = RX_START;
            RX_START: if (pos == LAST_START) nxt = RX_BODY;
            RX_BODY:  if (pos == LAST_BODY)  nxt = RX_PAR;
            RX_PAR:   if (pos == LAST_PAR)   nxt = RX_TAIL;
            RX_TAIL:  if (pos == LAST_BIT)   nxt = RX_IDLE;
            default:                         nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            pos <= '0;
        end else if (detect) begin
            sh  <= full;
            pos <= CW'(1);
        end else if (state != RX_IDLE) begin
            sh  <= full;
            pos <= done ? '0 : pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            ovw_q  <= 1'b0;
        end else if (done) begin
            data_q <= pay;
            rdy_q  <= 1'b1;
            par_q  <= bad_par;
            frm_q  <= bad_frm;
            ovw_q  <= rdy_q && !rx_rd;
        end else if (rx_rd) begin
            rdy_q  <= 1'b0;
        end
    end

    always_comb begin
        rx_data    = data_q;
        rx_ready   = rdy_q;
        rx_par_err = par_q;
        rx_frm_err = frm_q;
        rx_ovw_err = ovw_q;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !done) |=> $stable(rx_data));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !done) |=> !rx_ready);

    p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_ready && !rx_rd) |=> rx_ovw_err);

    p_read_and_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_rd) |=> (rx_ready && !rx_ovw_err));

    p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && rx_sleep) |=> (state == RX_IDLE));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(rx_par_err) && $stable(rx_frm_err) && $stable(rx_ovw_err)));
endmodule

// File: rtl/sflink_xcvr.sv
module sflink_xcvr #(
    parameter int unsigned PAY_W = 35,
    parameter int unsigned SW    = 3,
    parameter int unsigned EW    = 4,
    parameter logic [SW-1:0] START_PAT = 3'b101,
    parameter logic [EW-1:0] END_PAT   = 4'b0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_sleep,
    input  logic             tx_wr,
    input  logic [PAY_W-1:0] tx_data,
    output logic             tx_busy,
    output logic             ser_out,
    input  logic             rx_sleep,
    input  logic             ser_in,
    input  logic             rx_rd,
    output logic [PAY_W-1:0] rx_data,
    output logic             rx_ready,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_ovw_err
);
    sflink_tx #(
        .PAY_W(PAY_W), .SW(SW), .EW(EW),
        .START_PAT(START_PAT), .END_PAT(END_PAT)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_sleep (tx_sleep),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .tx_busy  (tx_busy),
        .ser_out  (ser_out)
    );

    sflink_rx #(
        .PAY_W(PAY_W), .SW(SW), .EW(EW),
        .START_PAT(START_PAT), .END_PAT(END_PAT)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_sleep   (rx_sleep),
        .ser_in     (ser_in),
        .rx_rd      (rx_rd),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err),
        .rx_ovw_err (rx_ovw_err)
    );
endmodule

// File: tb/sflink_xcvr_tb_top.sv
`timescale 1ns/1ps
module sflink_xcvr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_sleep = 1'b0, tx_wr = 1'b0;
    logic [34:0] tx_data = '0;
    logic        tx_busy, ser_out;
    logic        rx_sleep = 1'b0, rx_rd = 1'b0;
    logic        use_loop = 1'b1, inj = 1'b0;
    logic        ser_in;
    logic [34:0] rx_data;
    logic        rx_ready, rx_par_err, rx_frm_err, rx_ovw_err;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    assign ser_in = use_loop ? ser_out : inj;

    sflink_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .tx_sleep(tx_sleep), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_busy(tx_busy), .ser_out(ser_out),
        .rx_sleep(rx_sleep), .ser_in(ser_in), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_ovw_err(rx_ovw_err)
    );

    localparam logic [34:0] VEC [0:5] = '{
        35'h0_0000_0000, 35'h7_FFFF_FFFF, 35'h5_5555_5555,
        35'h2_AAAA_AAAA, 35'h1_2345_6789, 35'h4_0000_0001
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [43:0] mk(input logic [34:0] d, input bit flip_p0,
                                       input bit bad_start, input bit bad_end);
        logic [43:0] f;
        logic pe, po;
        pe = 1'b0; po = 1'b0;
        for (int i = 0; i < 35; i++) begin
            if (i % 2 == 0) pe = pe ^ d[i];
            else            po = po ^ d[i];
        end
        f = '0;
        f[0] = 1'b1; f[1] = bad_start; f[2] = 1'b1;
        for (int i = 0; i < 35; i++) f[3+i] = d[i];
        f[38] = pe ^ flip_p0;
        f[39] = po;
        f[43:40] = bad_end ? 4'b0100 : 4'b0000;
        return f;
    endfunction

    task automatic send(input logic [34:0] w, input bit interfere);
        logic [43:0] exp, cap;
        bit busy_ok;
        exp = mk(w, 0, 0, 0);
        busy_ok = 1'b1;
        @(negedge clk); tx_data = w; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        for (int k = 0; k < 44; k++) begin
            cap[k] = ser_out;
            if (!tx_busy) busy_ok = 1'b0;
            if (interfere && k == 10) begin tx_wr = 1'b1; tx_data = ~w; end
            else tx_wr = 1'b0;
            @(negedge clk);
        end
        tx_wr = 1'b0;
        check({cap[43:40], cap[37:0]} == {exp[43:40], exp[37:0]},
              interfere ? "R3 frame unchanged by write while busy" : "R1 frame bits",
              64'(cap), 64'(exp));
        check(cap[39:38] == exp[39:38], "R4 parity bits", 64'(cap[39:38]), 64'(exp[39:38]));
        check(busy_ok && !tx_busy, "R2 busy for 44 cycles", 64'(tx_busy), 64'(0));
    endtask

    task automatic inject(input logic [43:0] f, input bit rd_last);
        use_loop = 1'b0;
        for (int k = 0; k < 44; k++) begin
            inj = f[k];
            rx_rd = rd_last && (k == 43);
            @(negedge clk);
        end
        inj = 1'b0;
        rx_rd = 1'b0;
    endtask

    task automatic do_read();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        check(!rx_ready, "R5 read clears ready", 64'(rx_ready), 64'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!tx_busy && !ser_out && !rx_ready && !rx_par_err && !rx_frm_err && !rx_ovw_err
              && rx_data == '0, "R11 reset state",
              64'({tx_busy, ser_out, rx_ready, rx_par_err, rx_frm_err, rx_ovw_err}), 64'(0));

        // Table walk: loopback, each word sent, received, checked and read.
        for (int v = 0; v < 6; v++) begin
            send(VEC[v], 1'b0);
            check(rx_ready && rx_data == VEC[v] && !rx_par_err && !rx_frm_err && !rx_ovw_err,
                  "R5 loopback word", 64'(rx_data), 64'(VEC[v]));
            do_read();
            check(rx_data == VEC[v], "R5 data kept after read", 64'(rx_data), 64'(VEC[v]));
        end

        // R3 write while busy
        send(35'h3_0F0F_1234, 1'b1);
        check(rx_data == 35'h3_0F0F_1234, "R3 received original word", 64'(rx_data), 64'(35'h3_0F0F_1234));
        do_read();

        // R3 write under transmit sleep
        tx_sleep = 1'b1;
        tx_data = 35'h1_1111_1111; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        begin
            bit quiet;
            quiet = 1'b1;
            for (int k = 0; k < 46; k++) begin
                if (tx_busy || ser_out) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet && !rx_ready, "R3 sleep blocks write", 64'({tx_busy, ser_out, rx_ready}), 64'(0));
        end
        tx_sleep = 1'b0;

        // R7 parity error
        inject(mk(35'h0_1234_5678, 1, 0, 0), 1'b0);
        check(rx_ready && rx_par_err && !rx_frm_err && rx_data == 35'h0_1234_5678,
              "R7 parity error", 64'({rx_par_err, rx_frm_err}), 64'(2'b10));
        do_read();

        // R8 bad end code
        inject(mk(35'h6_0000_00FF, 0, 0, 1), 1'b0);
        check(rx_frm_err && !rx_par_err, "R8 bad end code", 64'({rx_par_err, rx_frm_err}), 64'(2'b01));
        do_read();

        // R8 bad start code
        inject(mk(35'h0_00FF_0000, 0, 1, 0), 1'b0);
        check(rx_frm_err && !rx_par_err, "R8 bad start code", 64'({rx_par_err, rx_frm_err}), 64'(2'b01));
        do_read();

        // R6 overwrite
        inject(mk(35'h0_0000_0AAA, 0, 0, 0), 1'b0);
        check(!rx_ovw_err && !rx_frm_err, "R11 flags refreshed on clean frame",
              64'({rx_ovw_err, rx_frm_err}), 64'(0));
        inject(mk(35'h0_0000_0BBB, 0, 0, 0), 1'b0);
        check(rx_ovw_err && rx_ready && rx_data == 35'h0_0000_0BBB, "R6 overwrite",
              64'(rx_data), 64'(35'h0_0000_0BBB));

        // R10 read in completion cycle
        inject(mk(35'h0_0000_0CCC, 0, 0, 0), 1'b1);
        check(rx_ready && !rx_ovw_err && rx_data == 35'h0_0000_0CCC, "R10 read with completion",
              64'({rx_ready, rx_ovw_err}), 64'(2'b10));
        do_read();

        // R9 receive sleep
        rx_sleep = 1'b1;
        inject(mk(35'h7_0000_0DDD, 0, 0, 0), 1'b0);
        repeat (2) @(negedge clk);
        check(!rx_ready && rx_data == 35'h0_0000_0CCC, "R9 sleep ignores frame",
              64'(rx_data), 64'(35'h0_0000_0CCC));
        rx_sleep = 1'b0;
        @(negedge clk);
        inject(mk(35'h7_0000_0EEE, 0, 0, 0), 1'b0);
        check(rx_ready && rx_data == 35'h7_0000_0EEE, "R9 receive after wake",
              64'(rx_data), 64'(35'h7_0000_0EEE));
        use_loop = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule